// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for every beat of an SDRAM read or write burst. A single-cycle start strobe loads an 8-bit start column together with the burst settings held in the memory's mode register: a 3-bit length code and an order bit. From the following cycle on, the block presents one column per clock, with a valid flag and a flag on the final beat. Moving the data, aligning to CAS latency and controlling the banks are left to the surrounding controller.

Finite bursts of 1, 2, 4 or 8 beats run in one of two orders. In sequential order the low address bits count upward and wrap inside the naturally aligned block. In interleaved order each column is the start column XOR the beat index. A full-page setting walks all 256 columns upward, wraps from 255 to 0 and keeps going until a terminate strobe arrives. A start strobe may arrive at any time, and the new burst then replaces the old one at once. Settings that have no defined meaning fall back to a single beat and raise an error pulse.

Top module: `burst_col_gen`

## Requirements
- R1: The cycle after a clock edge at which `start_i` is high, `valid_o` is 1 and `col_o` equals the `start_col_i` value sampled at that edge.
- R2: Length code 000 gives 1 beat, 001 gives 2, 010 gives 4 and 011 gives 8. After the last beat, `valid_o` returns to 0 unless a new start arrives.
- R3: With `order_i` = 0 (sequential), the low log2(length) bits step up by one per beat and wrap inside the aligned block. Start 0x45 with length 8 gives 45,46,47,40,41,42,43,44.
- R4: With `order_i` = 1 (interleaved), beat k presents start XOR k. Start 0x45 with length 8 gives 45,44,47,46,41,40,43,42.
- R5: During a finite burst, the column bits above the burst block keep the value they had in the start column.
- R6: Length code 111 with `order_i` = 0 selects full page: the column steps up by one per beat, wraps from 255 to 0 and continues with no natural end. `last_o` stays 0.
- R7: `last_o` is 1 exactly on the final beat of a finite burst, and only while `valid_o` is 1.
- R8: A clock edge at which `stop_i` is high and `start_i` is low ends any burst, so `valid_o` is 0 in the next cycle. When the block is idle, `stop_i` has no effect.
- R9: A start during a running burst restarts the sequence from the new column in the next cycle. Start takes priority over a stop at the same edge.
- R10: Length codes 100, 101 and 110, and code 111 with `order_i` = 1, produce a single beat at the start column with `last_o` = 1. `cfg_err_o` is 1 for exactly that one cycle.
- R11: While `rst_ni` is low and after it is released, `valid_o`, `last_o` and `cfg_err_o` are 0 until a start arrives.
- R12: While `valid_o` is 0, `col_o` reads 0 and `last_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a burst from `start_col_i` |
| start_col_i | input | 8 | First column of the burst |
| len_code_i | input | 3 | Burst length code from the mode register |
| order_i | input | 1 | 0 sequential, 1 interleaved |
| stop_i | input | 1 | Terminate the running burst |
| col_o | output | 8 | Column of the current beat |
| valid_o | output | 1 | A beat is presented this cycle |
| last_o | output | 1 | Current beat is the final one of a finite burst |
| cfg_err_o | output | 1 | One-cycle pulse for an unsupported length/order setting |

## Verification
The bench targets wrap points: starts in the middle or at the top of an aligned block, and a full-page run that crosses 255 to 0. A design that masks the sum wrongly would carry into the upper bits or would stop at 255. Interleaved starts with odd low bits separate XOR ordering from counting, so a generator that reuses the sequential path gives the wrong second beat. The bench also overlaps strobes: a restart in the middle of a burst, start and stop at the same edge, and a stop while idle. These catch a design that finishes the old burst, lets stop win, or wakes up from a stray stop. Undefined settings must collapse to one flagged beat rather than run with a stale or random length.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

  // Width of the burst-length code taken from the mode register.
  localparam int BL_CODE_W = 3;
  // Largest finite burst is 2**BL_MAX_LOG beats.
  localparam int BL_MAX_LOG = 3;
  // Code that selects the full-page run.
  localparam logic [BL_CODE_W-1:0] BL_CODE_PAGE = 3'b111;

  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_ILV = 1'b1
  } burst_order_e;

  // One column bit of the current beat.
  // Bits outside the burst block keep the start value. Inside the block,
  // interleaved order flips by the beat index and sequential order takes the sum.
  function automatic logic beat_bit(input logic in_block, input logic ilv,
                                    input logic base_b, input logic cnt_b,
                                    input logic sum_b);
    if (!in_block) return base_b;
    else if (ilv)  return base_b ^ cnt_b;
    else           return sum_b;
  endfunction

  // Low-bit mask of a finite burst of 2**log2_len beats.
  function automatic logic [31:0] block_mask(input logic [BL_CODE_W-1:0] log2_len);
    return (32'd1 << log2_len) - 32'd1;
  endfunction

endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
  import burst_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [BL_CODE_W-1:0] code_i,
  input  logic                 order_i,
  output logic [COL_W-1:0]     mask_o,
  output logic                 page_o,
  output logic                 ilv_o,
  output logic                 bad_o
);

  always_comb begin
    mask_o = '0;
    page_o = 1'b0;
    ilv_o  = 1'b0;
    bad_o  = 1'b0;
    if (code_i == BL_CODE_PAGE) begin
      if (order_i == ORD_ILV) begin
        bad_o = 1'b1;
      end else begin
        mask_o = '1;
        page_o = 1'b1;
      end
    end else if (int'(code_i) <= BL_MAX_LOG) begin
      mask_o = COL_W'(block_mask(code_i));
      ilv_o  = (order_i == ORD_ILV);
    end else begin
      bad_o = 1'b1;
    end
  end

endmodule

// File: rtl/burst_beat_ctrl.sv
module burst_beat_ctrl #(
  parameter int COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             page_i,
  input  logic             ilv_i,
  input  logic             bad_i,
  output logic             active_o,
  output logic [COL_W-1:0] base_o,
  output logic [COL_W-1:0] cnt_o,
  output logic [COL_W-1:0] mask_o,
  output logic             page_o,
  output logic             ilv_o,
  output logic             err_o,
  output logic             last_o
);

  logic at_end;

  // A finite burst ends when the beat index reaches the block mask.
  assign at_end = active_o && !page_o && (cnt_o == mask_o);
  assign last_o = at_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      base_o   <= '0;
      cnt_o    <= '0;
      mask_o   <= '0;
      page_o   <= 1'b0;
      ilv_o    <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      err_o <= start_i && bad_i;
      if (start_i) begin
        active_o <= 1'b1;
        base_o   <= col_i;
        cnt_o    <= '0;
        mask_o   <= mask_i;
        page_o   <= page_i;
        ilv_o    <= ilv_i;
      end else if (stop_i || at_end) begin
        active_o <= 1'b0;
      end else if (active_o) begin
        cnt_o <= cnt_o + COL_W'(1);
      end
    end
  end

endmodule

// File: rtl/burst_col_map.sv
module burst_col_map
  import burst_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] cnt_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o
);

  logic [COL_W-1:0] sum;

  // The block mask covers only low contiguous bits, so the carry into them
  // always comes from below and the sum needs no extra wrap logic.
  assign sum = base_i + cnt_i;

  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    assign col_o[b] = beat_bit(mask_i[b], ilv_i, base_i[b], cnt_i[b], sum[b]);
  end

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [COL_W-1:0]     start_col_i,
  input  logic [BL_CODE_W-1:0] len_code_i,
  input  logic                 order_i,
  input  logic                 stop_i,
  output logic [COL_W-1:0]     col_o,
  output logic                 valid_o,
  output logic                 last_o,
  output logic                 cfg_err_o
);

  logic [COL_W-1:0] dec_mask;
  logic             dec_page;
  logic             dec_ilv;
  logic             dec_bad;

  logic             active;
  logic [COL_W-1:0] base_col;
  logic [COL_W-1:0] beat_cnt;
  logic [COL_W-1:0] cur_mask;
  logic             cur_page;
  logic             cur_ilv;
  logic             cur_err;
  logic             cur_last;
  logic [COL_W-1:0] mapped_col;

  // Named events for the checker.
  logic start_evt;
  logic stop_evt;
  logic finish_evt;

  assign start_evt  = start_i;
  assign stop_evt   = stop_i && !start_i && active;
  assign finish_evt = cur_last && !start_i;

  burst_len_decode #(.COL_W(COL_W)) u_decode (
    .code_i  (len_code_i),
    .order_i (order_i),
    .mask_o  (dec_mask),
    .page_o  (dec_page),
    .ilv_o   (dec_ilv),
    .bad_o   (dec_bad)
  );

  burst_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_evt),
    .stop_i   (stop_i),
    .col_i    (start_col_i),
    .mask_i   (dec_mask),
    .page_i   (dec_page),
    .ilv_i    (dec_ilv),
    .bad_i    (dec_bad),
    .active_o (active),
    .base_o   (base_col),
    .cnt_o    (beat_cnt),
    .mask_o   (cur_mask),
    .page_o   (cur_page),
    .ilv_o    (cur_ilv),
    .err_o    (cur_err),
    .last_o   (cur_last)
  );

  burst_col_map #(.COL_W(COL_W)) u_map (
    .base_i (base_col),
    .cnt_i  (beat_cnt),
    .mask_i (cur_mask),
    .ilv_i  (cur_ilv),
    .col_o  (mapped_col)
  );

  assign col_o     = active ? mapped_col : '0;
  assign valid_o   = active;
  assign last_o    = cur_last;
  assign cfg_err_o = cur_err;

endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
  parameter int COL_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [COL_W-1:0] start_col_i,
  input logic             stop_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o,
  input logic             cfg_err_o,
  input logic [COL_W-1:0] blk_mask,
  input logic             page_mode,
  input logic             ilv_mode,
  input logic             stop_evt,
  input logic             finish_evt
);

  assert_start_loads_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (valid_o && col_o == $past(start_col_i)));

  assert_seq_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !last_o && !start_i && !stop_i && !ilv_mode)
    |=> (((col_o ^ ($past(col_o) + COL_W'(1))) & $past(blk_mask)) == '0));

  assert_upper_fixed_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !last_o && !start_i && !stop_i)
    |=> (((col_o ^ $past(col_o)) & ~$past(blk_mask)) == '0));

  assert_page_no_last_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    page_mode |-> !last_o);

  assert_last_ends_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    finish_evt |=> !valid_o);

  assert_stop_ends_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_evt || (stop_i && !start_i)) |=> !valid_o);

  assert_err_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> (valid_o && last_o));

  assert_idle_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (col_o == '0 && !last_o));

endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .start_col_i (start_col_i),
  .stop_i      (stop_i),
  .col_o       (col_o),
  .valid_o     (valid_o),
  .last_o      (last_o),
  .cfg_err_o   (cfg_err_o),
  .blk_mask    (cur_mask),
  .page_mode   (cur_page),
  .ilv_mode    (cur_ilv),
  .stop_evt    (stop_evt),
  .finish_evt  (finish_evt)
);

// File: tb/burst_col_gen_test.sv
module burst_col_gen_test;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] start_col_i = '0;
  logic [2:0] len_code_i = '0;
  logic       order_i = 1'b0;
  logic       stop_i = 1'b0;
  logic [7:0] col_o;
  logic       valid_o;
  logic       last_o;
  logic       cfg_err_o;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  always #5 clk_i = ~clk_i;

  burst_col_gen uut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .len_code_i  (len_code_i),
    .order_i     (order_i),
    .stop_i      (stop_i),
    .col_o       (col_o),
    .valid_o     (valid_o),
    .last_o      (last_o),
    .cfg_err_o   (cfg_err_o)
  );

  // code, order, start column, beats, error expected, columns (first beat in top byte)
  typedef struct packed {
    logic [2:0]  code;
    logic        ord;
    logic [7:0]  col;
    logic [3:0]  n;
    logic        bad;
    logic [63:0] seq;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{3'b011, 1'b0, 8'h45, 4'd8, 1'b0, 64'h4546_4740_4142_4344},
    '{3'b011, 1'b1, 8'h45, 4'd8, 1'b0, 64'h4544_4746_4140_4342},
    '{3'b010, 1'b0, 8'hA6, 4'd4, 1'b0, 64'hA6A7_A4A5_0000_0000},
    '{3'b010, 1'b1, 8'hA7, 4'd4, 1'b0, 64'hA7A6_A5A4_0000_0000},
    '{3'b001, 1'b0, 8'h33, 4'd2, 1'b0, 64'h3332_0000_0000_0000},
    '{3'b001, 1'b1, 8'h32, 4'd2, 1'b0, 64'h3233_0000_0000_0000},
    '{3'b000, 1'b0, 8'h9C, 4'd1, 1'b0, 64'h9C00_0000_0000_0000},
    '{3'b011, 1'b0, 8'hF8, 4'd8, 1'b0, 64'hF8F9_FAFB_FCFD_FEFF},
    '{3'b011, 1'b1, 8'h02, 4'd8, 1'b0, 64'h0203_0001_0607_0405},
    '{3'b101, 1'b0, 8'h17, 4'd1, 1'b1, 64'h1700_0000_0000_0000},
    '{3'b111, 1'b1, 8'h20, 4'd1, 1'b1, 64'h2000_0000_0000_0000},
    '{3'b110, 1'b1, 8'h81, 4'd1, 1'b1, 64'h8100_0000_0000_0000},
    '{3'b100, 1'b0, 8'h0F, 4'd1, 1'b1, 64'h0F00_0000_0000_0000}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Drive a start at a falling edge; returns at the next falling edge with beat 0 visible.
  task automatic launch(input logic [2:0] code, input logic ord, input logic [7:0] col,
                        input logic with_stop);
    @(negedge clk_i);
    start_i = 1'b1; len_code_i = code; order_i = ord; start_col_i = col; stop_i = with_stop;
    @(negedge clk_i);
    start_i = 1'b0; stop_i = 1'b0;
  endtask

  task automatic check_idle(input string req);
    check(valid_o == 1'b0, req, "valid when idle", 32'(valid_o), 0);
    check(col_o == 8'h00, "R12", "col when idle", 32'(col_o), 0);
    check(last_o == 1'b0, "R12", "last when idle", 32'(last_o), 0);
  endtask

  initial begin
    // R11: reset state
    #12;
    check(valid_o == 1'b0 && last_o == 1'b0 && cfg_err_o == 1'b0, "R11",
          "flags in reset", {29'd0, valid_o, last_o, cfg_err_o}, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    check(valid_o == 1'b0 && last_o == 1'b0 && cfg_err_o == 1'b0, "R11",
          "flags after reset", {29'd0, valid_o, last_o, cfg_err_o}, 0);
    check_idle("R11");

    // Table-driven bursts
    for (int v = 0; v < NV; v++) begin
      vec_t t;
      logic [7:0] hi_mask;
      t = VECS[v];
      hi_mask = ~(8'(t.n) - 8'd1);
      launch(t.code, t.ord, t.col, 1'b0);
      for (int k = 0; k < int'(t.n); k++) begin
        logic [7:0] exp_col;
        exp_col = t.seq[63 - 8*k -: 8];
        check(valid_o == 1'b1, (k == 0) ? "R1" : "R2", "valid in burst", 32'(valid_o), 1);
        check(col_o == exp_col, t.bad ? "R10" : (t.ord ? "R4" : "R3"), "column",
              32'(col_o), 32'(exp_col));
        if (!t.bad)
          check((col_o & hi_mask) == (t.col & hi_mask), "R5", "upper bits",
                32'(col_o & hi_mask), 32'(t.col & hi_mask));
        check(last_o == (k == int'(t.n) - 1), "R7", "last flag", 32'(last_o),
              32'(k == int'(t.n) - 1));
        check(cfg_err_o == (t.bad && k == 0), "R10", "error pulse", 32'(cfg_err_o),
              32'(t.bad && k == 0));
        @(negedge clk_i);
      end
      check_idle("R2");
      check(cfg_err_o == 1'b0, "R10", "error after burst", 32'(cfg_err_o), 0);
    end

    // R6: full page from 0xFE across the 255->0 wrap, then terminate (R8)
    launch(3'b111, 1'b0, 8'hFE, 1'b0);
    for (int k = 0; k < 300; k++) begin
      logic [7:0] exp_col;
      exp_col = 8'(8'hFE + k);
      check(valid_o == 1'b1 && col_o == exp_col, "R6", "page column", 32'(col_o), 32'(exp_col));
      check(last_o == 1'b0, "R6", "page last", 32'(last_o), 0);
      if (k == 299) stop_i = 1'b1;
      @(negedge clk_i);
    end
    stop_i = 1'b0;
    check_idle("R8");

    // R8: stop in the middle of a finite burst
    launch(3'b011, 1'b0, 8'h00, 1'b0);
    for (int k = 0; k < 3; k++) begin
      check(col_o == 8'(k), "R8", "column before stop", 32'(col_o), 32'(k));
      if (k == 2) stop_i = 1'b1;
      @(negedge clk_i);
    end
    stop_i = 1'b0;
    check_idle("R8");

    // R8: stop while idle has no effect
    stop_i = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i);
    stop_i = 1'b0;
    check_idle("R8");

    // R9: restart in the middle of a burst
    launch(3'b011, 1'b0, 8'h10, 1'b0);
    check(col_o == 8'h10, "R9", "first burst beat 0", 32'(col_o), 32'h10);
    @(negedge clk_i);
    check(col_o == 8'h11, "R9", "first burst beat 1", 32'(col_o), 32'h11);
    start_i = 1'b1; len_code_i = 3'b001; order_i = 1'b0; start_col_i = 8'h55;
    @(negedge clk_i);
    start_i = 1'b0;
    check(valid_o && col_o == 8'h55 && !last_o, "R9", "restart beat 0", 32'(col_o), 32'h55);
    @(negedge clk_i);
    check(valid_o && col_o == 8'h54 && last_o, "R9", "restart beat 1", 32'(col_o), 32'h54);
    @(negedge clk_i);
    check_idle("R9");

    // R9: start and stop at the same edge, start wins
    launch(3'b000, 1'b0, 8'h3A, 1'b1);
    check(valid_o && col_o == 8'h3A && last_o, "R9", "start beats stop", 32'(col_o), 32'h3A);
    @(negedge clk_i);
    check_idle("R9");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule